// File: doc/BRIEF.md
# Keyed Clock-Gating Request Controller

This block owns the clock enables of five accelerator engines. Software programs two 32-bit registers over a simple register bus. The mode register chooses, for each engine, how its clock is stopped. In direct mode the enable simply tracks the request. In handshake mode the controller first asks the engine to go idle, and it stops the clock only once the engine acknowledges.

The request register holds one gate/ungate request per engine. A 4-bit key in the top of a write to this register changes how the write acts. One key value turns the write into a set-only operation and another turns it into a clear-only operation. With either key, several agents can change their own engine's bit without a read-modify-write race. Any other key value performs a plain overwrite.

The actual clock-gating cells and the engines are outside the block. It drives one enable line and one idle-request line per engine, and it takes one idle-acknowledge line per engine.

Top module: `cg_ctrl`

## Requirements
- R1: While reset is high and after it is released, every request bit is 1, every mode bit is 0, every clk_en is 1 and every idle_req is 0.
- R2: The mode register is at word address 0 and the request register at word address 1. In each, bit i (i = 0..4) belongs to engine i. bus_rdata is combinational and returns the addressed register zero-extended when bus_rd is 1. It returns zero when bus_rd is 0 or the address is unmapped. Writes to unmapped addresses change nothing.
- R3: A request write whose bits [31:28] equal 4'h5 sets each request bit that has a 1 in bits [4:0] and leaves the other bits unchanged.
- R4: A request write whose bits [31:28] equal 4'h2 clears each request bit that has a 1 in bits [4:0] and leaves the other bits unchanged.
- R5: A request write with any other key value copies bits [4:0] into the request bits. Bits [31:5] of both registers, including the key field, always read as zero.
- R6: For an engine in direct mode (mode bit 0), clk_en takes the value of the request bit on the clock edge after the request bit changes. Its idle_req stays 0.
- R7: For an engine in handshake mode (mode bit 1), clearing the request raises idle_req one edge later while clk_en stays 1. clk_en falls on the first edge at which idle_ack is sampled high. idle_req stays high while the clock is gated.
- R8: Setting the request of an engine gated by handshake raises clk_en one edge later with idle_req still high. idle_req falls on the following edge.
- R9: Setting the request again while the controller is still waiting for idle_ack withdraws idle_req on the next edge, and clk_en never falls.
- R10: A mode bit change made while an engine's handshake is in progress does not affect that handshake. It applies from the next gate request that starts after the engine is back in its running state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read enable |
| bus_addr | input | 2 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| clk_en | output | 5 | Clock enable per engine |
| idle_req | output | 5 | Idle request per engine |
| idle_ack | input | 5 | Idle acknowledge per engine |

## Verification
The hardest situation to reach is a mode change that lands between idle_req rising and idle_ack arriving. The bench holds idle_ack low by hand for several cycles and rewrites the mode register inside that window. It then releases the acknowledge and confirms that the engine still gates through the handshake. Only the following gate request uses direct mode. A withdrawal during the same waiting window is driven the same way to show that the clock is never stopped.

// File: rtl/cg_pkg.sv
package cg_pkg;

    localparam int unsigned KEY_W = 4;
    localparam logic [KEY_W-1:0] KEY_SET_ONLY = 4'h5;
    localparam logic [KEY_W-1:0] KEY_CLR_ONLY = 4'h2;

    typedef enum logic [1:0] {
        WR_PLAIN = 2'd0,
        WR_SET   = 2'd1,
        WR_CLR   = 2'd2
    } wr_kind_e;

    typedef enum logic [2:0] {
        ENG_RUN     = 3'd0,
        ENG_OFF_DIR = 3'd1,
        ENG_ASK     = 3'd2,
        ENG_OFF_HS  = 3'd3,
        ENG_RESUME  = 3'd4
    } eng_state_e;

    typedef struct packed {
        logic clk_en;
        logic idle_req;
    } eng_out_t;

    function automatic wr_kind_e decode_key(input logic [KEY_W-1:0] key);
        case (key)
            KEY_SET_ONLY: return WR_SET;
            KEY_CLR_ONLY: return WR_CLR;
            default:      return WR_PLAIN;
        endcase
    endfunction

    function automatic eng_out_t state_outputs(input eng_state_e st);
        eng_out_t o;
        o.clk_en   = (st == ENG_RUN) || (st == ENG_ASK) || (st == ENG_RESUME);
        o.idle_req = (st == ENG_ASK) || (st == ENG_OFF_HS) || (st == ENG_RESUME);
        return o;
    endfunction

endpackage

// File: rtl/cg_regfile.sv
module cg_regfile
    import cg_pkg::*;
#(
    parameter int unsigned N_ENG    = 5,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned ADDR_W   = 2,
    parameter int unsigned MODE_ADR = 0,
    parameter int unsigned REQ_ADR  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [N_ENG-1:0]  mode_q,
    output logic [N_ENG-1:0]  req_q
);

    localparam int unsigned KEY_LSB = DATA_W - KEY_W;

    logic             hit_mode;
    logic             hit_req;
    wr_kind_e         kind;
    logic [N_ENG-1:0] wbits;
    logic [N_ENG-1:0] req_d;

    assign hit_mode = (addr == ADDR_W'(MODE_ADR));
    assign hit_req  = (addr == ADDR_W'(REQ_ADR));
    assign wbits    = wdata[N_ENG-1:0];
    assign kind     = decode_key(wdata[DATA_W-1:KEY_LSB]);

    always_comb begin
        case (kind)
            WR_SET:  req_d = req_q | wbits;
            WR_CLR:  req_d = req_q & ~wbits;
            default: req_d = wbits;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            req_q  <= '1;
        end else if (wr) begin
            if (hit_mode) mode_q <= wbits;
            if (hit_req)  req_q  <= req_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (rd) begin
            if (hit_mode)     rdata = DATA_W'(mode_q);
            else if (hit_req) rdata = DATA_W'(req_q);
        end
    end

    logic unused_wdata;
    assign unused_wdata = ^wdata[KEY_LSB-1:N_ENG];

endmodule

// File: rtl/cg_engine_fsm.sv
module cg_engine_fsm
    import cg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_on,
    input  logic hs_mode,
    input  logic idle_ack,
    output logic clk_en,
    output logic idle_req
);

    eng_state_e st_q;
    eng_state_e st_d;
    eng_out_t   outs;

    always_comb begin
        st_d = st_q;
        case (st_q)
            ENG_RUN: begin
                if (!req_on) st_d = hs_mode ? ENG_ASK : ENG_OFF_DIR;
            end
            ENG_OFF_DIR: begin
                if (req_on) st_d = ENG_RUN;
            end
            ENG_ASK: begin
                if (req_on)        st_d = ENG_RUN;
                else if (idle_ack) st_d = ENG_OFF_HS;
            end
            ENG_OFF_HS: begin
                if (req_on) st_d = ENG_RESUME;
            end
            ENG_RESUME: st_d = ENG_RUN;
            default:    st_d = ENG_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ENG_RUN;
        else     st_q <= st_d;
    end

    assign outs     = state_outputs(st_q);
    assign clk_en   = outs.clk_en;
    assign idle_req = outs.idle_req;

endmodule

// File: rtl/cg_ctrl.sv
module cg_ctrl
    import cg_pkg::*;
#(
    parameter int unsigned N_ENG    = 5,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned ADDR_W   = 2,
    parameter int unsigned MODE_ADR = 0,
    parameter int unsigned REQ_ADR  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [N_ENG-1:0]  clk_en,
    output logic [N_ENG-1:0]  idle_req,
    input  logic [N_ENG-1:0]  idle_ack
);

    logic [N_ENG-1:0] mode_q;
    logic [N_ENG-1:0] req_q;

    cg_regfile #(
        .N_ENG    (N_ENG),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .MODE_ADR (MODE_ADR),
        .REQ_ADR  (REQ_ADR)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (bus_wr),
        .rd     (bus_rd),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .rdata  (bus_rdata),
        .mode_q (mode_q),
        .req_q  (req_q)
    );

    for (genvar e = 0; e < N_ENG; e++) begin : g_eng
        cg_engine_fsm u_fsm (
            .clk      (clk),
            .rst      (rst),
            .req_on   (req_q[e]),
            .hs_mode  (mode_q[e]),
            .idle_ack (idle_ack[e]),
            .clk_en   (clk_en[e]),
            .idle_req (idle_req[e])
        );
    end

endmodule

// File: rtl/cg_ctrl_checker.sv
module cg_ctrl_checker #(
    parameter int unsigned N_ENG   = 5,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 2,
    parameter int unsigned REQ_ADR = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [N_ENG-1:0]  clk_en,
    input logic [N_ENG-1:0]  idle_req,
    input logic [N_ENG-1:0]  idle_ack,
    input logic [N_ENG-1:0]  req_q
);

    logic       req_wr;
    logic [3:0] key;
    assign req_wr = bus_wr && (bus_addr == ADDR_W'(REQ_ADR));
    assign key    = bus_wdata[DATA_W-1 -: 4];

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (clk_en == '1 && idle_req == '0 && req_q == '1));

    assert_key_set_R3: assert property (@(posedge clk) disable iff (rst)
        (req_wr && key == 4'h5) |=> req_q == ($past(req_q) | $past(bus_wdata[N_ENG-1:0])));

    assert_key_clr_R4: assert property (@(posedge clk) disable iff (rst)
        (req_wr && key == 4'h2) |=> req_q == ($past(req_q) & ~$past(bus_wdata[N_ENG-1:0])));

    assert_plain_write_R5: assert property (@(posedge clk) disable iff (rst)
        (req_wr && key != 4'h5 && key != 4'h2) |=> req_q == $past(bus_wdata[N_ENG-1:0]));

    assert_high_bits_zero_R5: assert property (@(posedge clk) disable iff (rst)
        bus_rd |-> bus_rdata[DATA_W-1:N_ENG] == '0);

    for (genvar e = 0; e < N_ENG; e++) begin : g_chk
        assert_gate_needs_ack_R7: assert property (@(posedge clk) disable iff (rst)
            ($fell(clk_en[e]) && $past(idle_req[e])) |-> $past(idle_ack[e]));

        assert_req_held_gated_R7: assert property (@(posedge clk) disable iff (rst)
            (idle_req[e] && !clk_en[e] && !req_q[e]) |=> idle_req[e]);

        assert_enable_before_release_R8: assert property (@(posedge clk) disable iff (rst)
            $fell(idle_req[e]) |-> clk_en[e]);
    end

endmodule

bind cg_ctrl cg_ctrl_checker #(
    .N_ENG   (N_ENG),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .REQ_ADR (REQ_ADR)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .clk_en    (clk_en),
    .idle_req  (idle_req),
    .idle_ack  (idle_ack),
    .req_q     (req_q)
);

// File: tb/tb_cg_ctrl.sv
`timescale 1ns/1ps
module tb_cg_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [4:0]  clk_en;
    logic [4:0]  idle_req;
    logic [4:0]  idle_ack = '0;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    cg_ctrl dut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .clk_en    (clk_en),
        .idle_req  (idle_req),
        .idle_ack  (idle_ack)
    );

    // {addr[1:0], wdata[31:0], expected request[4:0], expected mode[4:0]}
    localparam int NV = 14;
    localparam logic [43:0] VEC [NV] = '{
        {2'd1, 32'h0000_0000, 5'h00, 5'h00},  // R5 plain
        {2'd1, 32'h5000_0005, 5'h05, 5'h00},  // R3 set
        {2'd1, 32'h5000_0012, 5'h17, 5'h00},  // R3 set
        {2'd1, 32'h2000_0003, 5'h14, 5'h00},  // R4 clear
        {2'd1, 32'h2000_0000, 5'h14, 5'h00},  // R4 clear nothing
        {2'd1, 32'h5000_0000, 5'h14, 5'h00},  // R3 set nothing
        {2'd1, 32'h3000_000B, 5'h0B, 5'h00},  // R5 other key
        {2'd1, 32'hF000_0015, 5'h15, 5'h00},  // R5 other key
        {2'd1, 32'h0000_FFE0, 5'h00, 5'h00},  // R5 upper bits dropped
        {2'd0, 32'hFFFF_FFE0, 5'h00, 5'h00},  // R2 mode upper bits dropped
        {2'd2, 32'h0000_001F, 5'h00, 5'h00},  // R2 unmapped write
        {2'd1, 32'h5000_001F, 5'h1F, 5'h00},  // R3 set all
        {2'd1, 32'h2000_0010, 5'h0F, 5'h00},  // R4 clear one
        {2'd1, 32'h7000_001F, 5'h1F, 5'h00}   // R5 key 7
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] rv;
        repeat (3) @(negedge clk);
        chk("R1 clk_en in reset", 32'(clk_en), 32'h1F);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 clk_en", 32'(clk_en), 32'h1F);
        chk("R1 idle_req", 32'(idle_req), 32'h0);
        bus_read(2'd1, rv); chk("R1 request", rv, 32'h1F);
        bus_read(2'd0, rv); chk("R1 mode", rv, 32'h0);

        // table walk, all engines in direct mode
        for (int i = 0; i < NV; i++) begin
            logic [1:0]  va;
            logic [31:0] vd;
            logic [4:0]  vr, vm;
            {va, vd, vr, vm} = VEC[i];
            bus_write(va, vd);
            @(negedge clk);
            chk($sformatf("R6 vec%0d clk_en", i), 32'(clk_en), 32'(vr));
            chk($sformatf("R6 vec%0d idle_req", i), 32'(idle_req), 32'h0);
            bus_read(2'd1, rv); chk($sformatf("R3/R4/R5 vec%0d request", i), rv, 32'(vr));
            bus_read(2'd0, rv); chk($sformatf("R2 vec%0d mode", i), rv, 32'(vm));
        end

        // R2 read enable low and unmapped read
        @(negedge clk);
        bus_rd = 1'b0; bus_addr = 2'd1;
        #1 chk("R2 rd low", bus_rdata, 32'h0);
        bus_read(2'd3, rv); chk("R2 unmapped read", rv, 32'h0);

        // R7/R10: engine 0 handshake, mode flipped mid-flight
        bus_write(2'd0, 32'h1);
        bus_write(2'd1, 32'h2000_0001);
        chk("R7 idle_req not yet", 32'(idle_req), 32'h0);
        @(negedge clk);
        chk("R7 idle_req up", 32'(idle_req), 32'h1);
        chk("R7 clk_en kept", 32'(clk_en), 32'h1F);
        repeat (3) @(negedge clk);
        chk("R7 waits for ack", 32'(clk_en), 32'h1F);
        bus_write(2'd0, 32'h0);
        @(negedge clk);
        chk("R10 still waiting clk_en", 32'(clk_en), 32'h1F);
        chk("R10 still waiting idle_req", 32'(idle_req), 32'h1);
        idle_ack = 5'h01;
        @(negedge clk);
        chk("R7 gated after ack", 32'(clk_en), 32'h1E);
        chk("R7 idle_req held", 32'(idle_req), 32'h1);
        repeat (2) @(negedge clk);
        chk("R7 idle_req held while gated", 32'(idle_req), 32'h1);
        bus_write(2'd1, 32'h5000_0001);
        chk("R8 not yet", 32'(clk_en), 32'h1E);
        @(negedge clk);
        chk("R8 clk_en restored", 32'(clk_en), 32'h1F);
        chk("R8 idle_req still up", 32'(idle_req), 32'h1);
        @(negedge clk);
        chk("R8 idle_req released", 32'(idle_req), 32'h0);
        idle_ack = 5'h00;
        bus_write(2'd1, 32'h2000_0001);
        @(negedge clk);
        chk("R10 direct now clk_en", 32'(clk_en), 32'h1E);
        chk("R10 direct now idle_req", 32'(idle_req), 32'h0);
        bus_write(2'd1, 32'h5000_0001);
        @(negedge clk);
        chk("R6 direct ungate", 32'(clk_en), 32'h1F);

        // R9: withdraw while waiting on engine 2
        bus_write(2'd0, 32'h4);
        bus_write(2'd1, 32'h2000_0004);
        @(negedge clk);
        chk("R9 idle_req up", 32'(idle_req), 32'h4);
        bus_write(2'd1, 32'h5000_0004);
        chk("R9 clk_en kept", 32'(clk_en), 32'h1F);
        @(negedge clk);
        chk("R9 idle_req withdrawn", 32'(idle_req), 32'h0);
        chk("R9 clk_en never fell", 32'(clk_en), 32'h1F);

        // independent engines: 3 handshake, 4 direct
        bus_write(2'd0, 32'h8);
        bus_write(2'd1, 32'h2000_0018);
        @(negedge clk);
        chk("R6 engine4 direct off", 32'(clk_en), 32'h0F);
        chk("R7 engine3 asks", 32'(idle_req), 32'h08);
        idle_ack = 5'h08;
        @(negedge clk);
        chk("R7 engine3 gated", 32'(clk_en), 32'h07);
        bus_write(2'd1, 32'h5000_0018);
        @(negedge clk);
        chk("R8 both back", 32'(clk_en), 32'h1F);
        chk("R8 engine3 req still up", 32'(idle_req), 32'h08);
        @(negedge clk);
        chk("R8 engine3 released", 32'(idle_req), 32'h00);
        idle_ack = 5'h00;

        // R1: reset from a gated state
        bus_write(2'd0, 32'h0);
        bus_write(2'd1, 32'h0000_0000);
        @(negedge clk);
        chk("R6 all off", 32'(clk_en), 32'h00);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 clk_en after reset", 32'(clk_en), 32'h1F);
        bus_read(2'd1, rv); chk("R1 request after reset", rv, 32'h1F);

        finish_run();
    end

endmodule